// File: doc/BRIEF.md
# Brown-out Reset Sequencer

This block is the reset controller of a small microcontroller core. It watches two digital brown-out comparator outputs. A high comparator output means the supply is at or below that level's threshold. The level-0 comparator always causes a full reset. The level-1 comparator causes a reset only when software has set its enable bit. The block runs entirely on the low-speed oscillator clock, which is also its own clock. It holds the internal reset while a brown-out persists. Once the supply recovers, it counts a release delay on that clock and then lets go of the reset.

The block has two reset outputs. `sys_rst_o` resets the pins, the CPU and the configuration registers on any brown-out. `mode_rst_o` additionally reaches the processor-mode bits and the other preserved registers, and it is asserted only by a level-0 or power-on reset. After every reset the CPU clock select is forced to the oscillator divided by 8. A readable cause register records a warm-start flag and one flag for each brown-out level; software clears the level flags by writing 1. The block drives no RAM clear, so RAM survives every brown-out. `rst_i` is the synchronous power-on reset.

Top module: `bor_rstseq`

## Requirements
- R1: While `lvl0_cmp_i` is 1, `sys_rst_o` and `mode_rst_o` are both 1. This takes effect at once, with no clock edge needed.
- R2: After `lvl0_cmp_i` falls, `sys_rst_o` and `mode_rst_o` fall after exactly LVL0_CYCLES+2 rising clock edges. The two extra edges are the synchronizer stages, and the default is 34 edges. After `rst_i` falls, both fall after exactly LVL0_CYCLES edges.
- R3: When `lvl1_en_o` is 0, a high `lvl1_cmp_i` leaves `sys_rst_o` at 0 and leaves `cause_o` unchanged.
- R4: When `lvl1_en_o` is 1, a high `lvl1_cmp_i` drives `sys_rst_o` to 1 at once, while `mode_rst_o` stays 0. After the input falls, `sys_rst_o` falls after max(D,1)+2 edges, where D is the delay register written through `sw_dly_we` and `sw_dly_d`.
- R5: A brown-out of either level that arrives during a release countdown restarts the count from zero. The release is then timed from the end of the new event.
- R6: `clk_sel_o` uses the encoding 0 = divide by 1, 1 = divide by 2, 2 = divide by 4, 3 = divide by 8. When any reset is released, it reads 3 (divide by 8).
- R7: A full reset (`rst_i`, or level 0) sets these values:
  - `mode_o` to 0;
  - `lvl1_en_o` to 0;
  - the delay register to DLY_DEFAULT (default 32);
  - `cause_o[0]` (the warm flag) to 0;
  - `cause_o[2]` (the level-1 flag) to 0;
  - `cause_o[1]` (the level-0 flag) to 1 after a level-0 reset, or to 0 after `rst_i`.
- R8: A level-1 reset sets `cause_o[2]` to 1. It leaves `mode_o`, `lvl1_en_o`, the delay register, `cause_o[0]` and `cause_o[1]` unchanged.
- R9: A pulse on `sw_warm_set` sets `cause_o[0]`. Setting bit 0 of `sw_flag_clr` clears `cause_o[1]`, and setting bit 1 clears `cause_o[2]`. Zero bits in `sw_flag_clr` have no effect.
- R10: When both comparators go high together, the reset behaves as a level-0 reset: `mode_rst_o` is 1, the release takes 34 edges, and afterwards `cause_o` = 3'b010.
- R11: Every software write strobe is ignored while `sys_rst_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed oscillator clock |
| rst_i | input | 1 | Synchronous power-on reset, active high |
| lvl0_cmp_i | input | 1 | Level-0 comparator, 1 = supply at or below threshold |
| lvl1_cmp_i | input | 1 | Level-1 comparator, 1 = supply at or below threshold |
| sw_mode_we | input | 1 | Write strobe for the mode bits |
| sw_mode_d | input | 2 | Mode bits write data |
| sw_en_we | input | 1 | Write strobe for the level-1 enable |
| sw_en_d | input | 1 | Level-1 enable write data |
| sw_dly_we | input | 1 | Write strobe for the level-1 release delay |
| sw_dly_d | input | DLY_W | Release delay write data |
| sw_clk_we | input | 1 | Write strobe for the clock select |
| sw_clk_d | input | 2 | Clock select write data |
| sw_warm_set | input | 1 | Sets the warm-start flag |
| sw_flag_clr | input | 2 | Write-1-to-clear for the level-0 (bit 0) and level-1 (bit 1) flags |
| sys_rst_o | output | 1 | System reset for pins, CPU and registers |
| mode_rst_o | output | 1 | Reset for the preserved mode registers (full reset only) |
| clk_sel_o | output | 2 | CPU clock divider select |
| mode_o | output | 2 | Processor-mode bits |
| lvl1_en_o | output | 1 | Level-1 reset enable |
| cause_o | output | 3 | Cause register: {level-1 flag, level-0 flag, warm flag} |

## Verification
The bench sweeps the level-1 delay from 0 to 40 and measures the release edge by edge. An off-by-one counter, a missing synchronizer stage or an unclamped zero delay shows up as a wrong edge count, and a zero delay that is not clamped would leave the block stuck in reset. It pulses a one-cycle brown-out during both kinds of countdown. A design that does not restart its counter would release early. A level-1 reset is checked to keep the mode bits, the enable and the warm flag. A design that routed level 1 to the full reset would clear them and raise `mode_rst_o`. The bench also raises both comparators together and writes registers while reset is held. A wrong priority would leave the level-1 flag set, and a missing write gate would let the clock select leave divide-by-8 or set the warm flag.

// File: rtl/bor_pkg.sv
package bor_pkg;

    typedef enum logic [1:0] {
        CLK_DIV1 = 2'd0,
        CLK_DIV2 = 2'd1,
        CLK_DIV4 = 2'd2,
        CLK_DIV8 = 2'd3
    } clk_sel_e;

    typedef enum logic {
        SEQ_FULL = 1'b0,
        SEQ_PART = 1'b1
    } seq_kind_e;

    typedef struct packed {
        logic lvl1;
        logic lvl0;
        logic warm;
    } cause_t;

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= d_i[i];
                s2_q <= s1_q;
            end
        end
        assign q_o[i] = s2_q;
    end
endmodule

// File: rtl/bor_seq.sv
module bor_seq
    import bor_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int LVL0_CYCLES = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             hold_full_i,
    input  logic             hold_part_i,
    input  logic [CNT_W-1:0] part_limit_i,
    output logic             active_o,
    output logic             full_o
);
    localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(LVL0_CYCLES);

    seq_kind_e        kind_q;
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    assign lim = (kind_q == SEQ_FULL) ? FULL_LIM : part_limit_i;

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_full_i) begin
            active_q <= 1'b1;
            kind_q   <= SEQ_FULL;
            cnt_q    <= '0;
        end else if (hold_part_i) begin
            active_q <= 1'b1;
            kind_q   <= (active_q && kind_q == SEQ_FULL) ? SEQ_FULL : SEQ_PART;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (cnt_q == lim - 1'b1) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign full_o   = active_q && (kind_q == SEQ_FULL);
endmodule

// File: rtl/bor_regs.sv
module bor_regs
    import bor_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int DLY_DEFAULT = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             hold_full_i,
    input  logic             hold_part_i,
    input  logic             wr_ok_i,
    input  logic             sw_mode_we,
    input  logic [1:0]       sw_mode_d,
    input  logic             sw_en_we,
    input  logic             sw_en_d,
    input  logic             sw_dly_we,
    input  logic [DLY_W-1:0] sw_dly_d,
    input  logic             sw_clk_we,
    input  logic [1:0]       sw_clk_d,
    input  logic             sw_warm_set,
    input  logic [1:0]       sw_flag_clr,
    output logic [1:0]       mode_o,
    output logic             lvl1_en_o,
    output logic [DLY_W-1:0] dly_o,
    output clk_sel_e         clk_sel_o,
    output cause_t           cause_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i || hold_full_i) begin
            mode_o       <= 2'b00;
            lvl1_en_o    <= 1'b0;
            dly_o        <= DLY_W'(DLY_DEFAULT);
            clk_sel_o    <= CLK_DIV8;
            cause_o.warm <= 1'b0;
            cause_o.lvl0 <= !rst_i;
            cause_o.lvl1 <= 1'b0;
        end else if (hold_part_i) begin
            cause_o.lvl1 <= 1'b1;
            clk_sel_o    <= CLK_DIV8;
        end else if (wr_ok_i) begin
            if (sw_mode_we) mode_o    <= sw_mode_d;
            if (sw_en_we)   lvl1_en_o <= sw_en_d;
            if (sw_dly_we)  dly_o     <= sw_dly_d;
            if (sw_clk_we)  clk_sel_o <= clk_sel_e'(sw_clk_d);
            if (sw_warm_set)    cause_o.warm <= 1'b1;
            if (sw_flag_clr[0]) cause_o.lvl0 <= 1'b0;
            if (sw_flag_clr[1]) cause_o.lvl1 <= 1'b0;
        end
    end
endmodule

// File: rtl/bor_rstseq.sv
module bor_rstseq
    import bor_pkg::*;
#(
    parameter int DLY_W       = 8,
    parameter int DLY_DEFAULT = 32,
    parameter int LVL0_CYCLES = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             lvl0_cmp_i,
    input  logic             lvl1_cmp_i,
    input  logic             sw_mode_we,
    input  logic [1:0]       sw_mode_d,
    input  logic             sw_en_we,
    input  logic             sw_en_d,
    input  logic             sw_dly_we,
    input  logic [DLY_W-1:0] sw_dly_d,
    input  logic             sw_clk_we,
    input  logic [1:0]       sw_clk_d,
    input  logic             sw_warm_set,
    input  logic [1:0]       sw_flag_clr,
    output logic             sys_rst_o,
    output logic             mode_rst_o,
    output logic [1:0]       clk_sel_o,
    output logic [1:0]       mode_o,
    output logic             lvl1_en_o,
    output logic [2:0]       cause_o
);
    localparam int CNT_W = max_u(DLY_W, $clog2(LVL0_CYCLES + 1));

    logic [1:0]       cmp_s;
    logic             hold_full, hold_part;
    logic             active, full_active;
    logic [DLY_W-1:0] dly_q, dly_eff;
    clk_sel_e         clk_sel;
    cause_t           cause;

    bor_sync #(.N(2)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({lvl1_cmp_i, lvl0_cmp_i}),
        .q_o   (cmp_s)
    );

    assign hold_full = cmp_s[0];
    assign hold_part = cmp_s[1] && lvl1_en_o && !cmp_s[0];
    assign dly_eff   = (dly_q == '0) ? DLY_W'(1) : dly_q;

    bor_seq #(.CNT_W(CNT_W), .LVL0_CYCLES(LVL0_CYCLES)) u_seq (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .hold_full_i  (hold_full),
        .hold_part_i  (hold_part),
        .part_limit_i (CNT_W'(dly_eff)),
        .active_o     (active),
        .full_o       (full_active)
    );

    assign sys_rst_o  = active || lvl0_cmp_i || (lvl1_cmp_i && lvl1_en_o);
    assign mode_rst_o = full_active || lvl0_cmp_i;

    bor_regs #(.DLY_W(DLY_W), .DLY_DEFAULT(DLY_DEFAULT)) u_regs (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .hold_full_i (hold_full),
        .hold_part_i (hold_part),
        .wr_ok_i     (!sys_rst_o),
        .sw_mode_we  (sw_mode_we),
        .sw_mode_d   (sw_mode_d),
        .sw_en_we    (sw_en_we),
        .sw_en_d     (sw_en_d),
        .sw_dly_we   (sw_dly_we),
        .sw_dly_d    (sw_dly_d),
        .sw_clk_we   (sw_clk_we),
        .sw_clk_d    (sw_clk_d),
        .sw_warm_set (sw_warm_set),
        .sw_flag_clr (sw_flag_clr),
        .mode_o      (mode_o),
        .lvl1_en_o   (lvl1_en_o),
        .dly_o       (dly_q),
        .clk_sel_o   (clk_sel),
        .cause_o     (cause)
    );

    assign clk_sel_o = clk_sel;
    assign cause_o   = cause;
endmodule

// File: rtl/bor_rstseq_chk.sv
module bor_rstseq_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       lvl0_cmp_i,
    input logic       lvl1_cmp_i,
    input logic       sys_rst_o,
    input logic       mode_rst_o,
    input logic [1:0] clk_sel_o,
    input logic       lvl1_en_o,
    input logic [2:0] cause_o
);
    AST_LVL0_HOLDS_BOTH: assert property (@(posedge clk_i) disable iff (rst_i)
        lvl0_cmp_i |-> (sys_rst_o && mode_rst_o)); // R1

    AST_LVL1_ENABLED_RESETS: assert property (@(posedge clk_i) disable iff (rst_i)
        (lvl1_cmp_i && lvl1_en_o) |-> sys_rst_o); // R4

    AST_MODE_WITHIN_SYS: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_rst_o |-> sys_rst_o); // R4

    AST_RELEASE_DIV8: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sys_rst_o) |-> (clk_sel_o == 2'd3)); // R6

    AST_LVL1_FLAG_SET: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(sys_rst_o) && !$past(mode_rst_o)) |-> cause_o[2]); // R8
endmodule

bind bor_rstseq bor_rstseq_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .lvl0_cmp_i (lvl0_cmp_i),
    .lvl1_cmp_i (lvl1_cmp_i),
    .sys_rst_o  (sys_rst_o),
    .mode_rst_o (mode_rst_o),
    .clk_sel_o  (clk_sel_o),
    .lvl1_en_o  (lvl1_en_o),
    .cause_o    (cause_o)
);

// File: tb/bor_rstseq_bench.sv
`timescale 1ns/1ps
module bor_rstseq_bench;
    localparam int DLY_W = 8;

    logic clk = 1'b0;
    logic rst, lvl0, lvl1;
    logic mode_we, en_we, en_d, dly_we, clk_we, warm_set;
    logic [1:0] mode_d, clk_d, flag_clr;
    logic [DLY_W-1:0] dly_d;
    logic sys_rst, mode_rst, lvl1_en;
    logic [1:0] clk_sel, mode;
    logic [2:0] cause;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bor_rstseq u_bor_rstseq (
        .clk_i(clk), .rst_i(rst), .lvl0_cmp_i(lvl0), .lvl1_cmp_i(lvl1),
        .sw_mode_we(mode_we), .sw_mode_d(mode_d), .sw_en_we(en_we), .sw_en_d(en_d),
        .sw_dly_we(dly_we), .sw_dly_d(dly_d), .sw_clk_we(clk_we), .sw_clk_d(clk_d),
        .sw_warm_set(warm_set), .sw_flag_clr(flag_clr),
        .sys_rst_o(sys_rst), .mode_rst_o(mode_rst), .clk_sel_o(clk_sel),
        .mode_o(mode), .lvl1_en_o(lvl1_en), .cause_o(cause)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count rising edges until sys_rst is seen low at a falling edge
    task automatic count_release(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (!sys_rst) return;
        end
        n = 999;
    endtask

    task automatic wr_mode(logic [1:0] v);
        mode_d = v; mode_we = 1'b1; @(negedge clk); mode_we = 1'b0;
    endtask
    task automatic wr_en(logic v);
        en_d = v; en_we = 1'b1; @(negedge clk); en_we = 1'b0;
    endtask
    task automatic wr_dly(int v);
        dly_d = DLY_W'(v); dly_we = 1'b1; @(negedge clk); dly_we = 1'b0;
    endtask
    task automatic wr_clk(logic [1:0] v);
        clk_d = v; clk_we = 1'b1; @(negedge clk); clk_we = 1'b0;
    endtask
    task automatic wr_clr(logic [1:0] v);
        flag_clr = v; @(negedge clk); flag_clr = 2'b00;
    endtask
    task automatic wr_warm();
        warm_set = 1'b1; @(negedge clk); warm_set = 1'b0;
    endtask

    initial begin
        #(20ns * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; lvl0 = 1'b0; lvl1 = 1'b0;
        mode_we = 0; en_we = 0; en_d = 0; dly_we = 0; clk_we = 0; warm_set = 0;
        mode_d = 0; clk_d = 0; flag_clr = 0; dly_d = 0;
        cycles(3);
        check("R7 reset sys_rst", sys_rst, 1);
        check("R7 reset mode_rst", mode_rst, 1);
        check("R6 reset clk_sel", clk_sel, 3);
        check("R7 reset cause", cause, 0);
        rst = 1'b0;
        count_release(n);
        check("R2 power-on release edges", n, 32);
        check("R7 mode after por", mode, 0);
        check("R7 enable after por", lvl1_en, 0);

        // R9 software fields
        wr_mode(2'b01); wr_clk(2'd0); wr_warm();
        check("R9 warm set", cause, 3'b001);
        check("R6 clk write", clk_sel, 0);

        // R3 disabled level 1
        lvl1 = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R3 disabled no reset", sys_rst, 0);
        end
        lvl1 = 1'b0; cycles(3);
        check("R3 disabled cause kept", cause, 3'b001);

        // R4/R8 sweep of the level-1 delay
        wr_en(1'b1);
        for (int d = 0; d <= 40; d++) begin
            wr_dly(d);
            lvl1 = 1'b1; #1;
            check("R4 lvl1 immediate", sys_rst, 1);
            cycles(4);
            check("R4 lvl1 spares mode_rst", mode_rst, 0);
            lvl1 = 1'b0;
            count_release(n);
            check("R4 lvl1 release edges", n, (d == 0 ? 1 : d) + 2);
            check("R8 mode kept", mode, 1);
            check("R8 enable kept", lvl1_en, 1);
            check("R8 cause flags", cause, 3'b101);
            check("R6 div8 after lvl1", clk_sel, 3);
            wr_clr(2'b00);
            check("R9 zero clear ignored", cause, 3'b101);
            wr_clr(2'b10);
            check("R9 lvl1 flag cleared", cause, 3'b001);
            wr_clk(2'd0);
        end

        // R5 restart during a level-1 countdown
        wr_dly(10);
        lvl1 = 1'b1; cycles(4); lvl1 = 1'b0; cycles(5);
        lvl1 = 1'b1; @(negedge clk); lvl1 = 1'b0;
        count_release(n);
        check("R5 lvl1 restart edges", n, 12);
        wr_clr(2'b10);

        // R1/R5/R11 level 0 with restart and writes during reset
        lvl0 = 1'b1; #1;
        check("R1 sys_rst immediate", sys_rst, 1);
        check("R1 mode_rst immediate", mode_rst, 1);
        cycles(3);
        wr_warm(); wr_clk(2'd1); wr_mode(2'b11); wr_en(1'b1); wr_dly(3);
        lvl0 = 1'b0; cycles(10);
        lvl0 = 1'b1; @(negedge clk); lvl0 = 1'b0;
        count_release(n);
        check("R5 lvl0 restart edges", n, 34);
        check("R11 warm write ignored", cause, 3'b010);
        check("R11 clk write ignored", clk_sel, 3);
        check("R7 mode cleared", mode, 0);
        check("R7 enable cleared", lvl1_en, 0);

        // R7 delay back to default
        wr_en(1'b1);
        lvl1 = 1'b1; cycles(4); lvl1 = 1'b0;
        count_release(n);
        check("R7 default delay edges", n, 34);
        wr_clr(2'b11);
        check("R9 both flags cleared", cause, 0);

        // R2 plain level-0 release
        lvl0 = 1'b1; cycles(5); lvl0 = 1'b0;
        count_release(n);
        check("R2 lvl0 release edges", n, 34);
        wr_clr(2'b01);

        // R10 both together
        wr_en(1'b1); wr_mode(2'b10);
        lvl0 = 1'b1; lvl1 = 1'b1; cycles(4);
        check("R10 mode_rst", mode_rst, 1);
        lvl0 = 1'b0; lvl1 = 1'b0;
        count_release(n);
        check("R10 release edges", n, 34);
        check("R10 cause", cause, 3'b010);
        check("R10 mode cleared", mode, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule